// File: doc/BRIEF.md
# Cascadable Up/Down Counter Stage

This block is one slice of a wide event counter. It adds or removes one from an 8-bit count on the rising edge of one of two active-low pulse inputs. One input counts up and the other counts down. The slice produces active-low carry and borrow pulses, so another slice of the same kind can take them as its own up and down inputs. A chain of slices widens the count 8 bits at a time. The lowest slice is driven by any pulse source that keeps one input high while it pulses the other.

All three control inputs are asynchronous to the system clock. The two pulse inputs and the active-high clear each pass through a multi-flop synchronizer. Edges are detected in the clock domain. A carry stays low for as long as the synchronized up input is low while the count sits at its maximum. A borrow stays low for as long as the synchronized down input is low while the count is zero, or while the clear is active. The pulse widths therefore follow the input pulses through any depth of chain. A busy output tells a downstream capture stage that a count is in flight. If a count edge arrives while the other input is also low, the slice holds its count and raises an error pulse.

Top module: `ucs_stage`

## Requirements
- R1: A rising edge on the synchronized up input, while the down input is high, adds one to the count (modulo 2^WIDTH).
- R2: A rising edge on the synchronized down input, while the up input is high, subtracts one from the count (modulo 2^WIDTH).
- R3: A count edge on one input while the other input is low, or rising edges on both inputs in the same cycle, leaves the count unchanged and drives `err` high for exactly one cycle.
- R4: While the synchronized clear is high, the count is forced to zero, and up and down pulses do not change it.
- R5: While the up input is low and the count is all ones, `carry_n` is low. It returns high on the same edge on which the count wraps to zero.
- R6: While the down input is low and the count is zero, `borrow_n` is low. It returns high on the same edge on which the count wraps to all ones.
- R7: A down pulse during clear still drives `borrow_n` low for its low period, and the count stays zero.
- R8: After reset the count is zero, `carry_n` and `borrow_n` are high, and `busy` and `err` are low. Whenever `busy` is low, both pulse outputs are high on the next cycle.
- R9: `busy` is high exactly while the synchronized up or down input is low.
- R10: Two slices, where the upper slice's up and down inputs take the lower slice's `carry_n` and `borrow_n`, form one 2*WIDTH-bit counter. This holds across wraps in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the clock-domain state |
| up_n | input | 1 | Active-low up-count pulse; counts on its rising edge |
| dn_n | input | 1 | Active-low down-count pulse; counts on its rising edge |
| clr | input | 1 | Active-high counter clear, asynchronous |
| count | output | WIDTH | Current count value |
| carry_n | output | 1 | Active-low carry pulse toward the next slice |
| borrow_n | output | 1 | Active-low borrow pulse toward the next slice |
| busy | output | 1 | High while a count pulse is in progress |
| err | output | 1 | One-cycle pulse when a count edge is rejected because both inputs were low |

## Verification
Two slices are chained into a 16-bit counter and compared against a reference integer. The stimulus includes runs of up pulses, runs of down pulses, and crossings of the low byte in both directions, including the wrap from zero down to all ones and back. These patterns separate a plain increment or decrement from the carry and borrow propagation into the upper slice. A held down input with an up pulse inside it shows whether a rejected edge is told apart from a valid count. Pulses under clear show that the count is forced while the borrow still appears.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

   // Count operation decided from the detected input edges
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_INC  = 2'd1,
      OP_DEC  = 2'd2,
      OP_BAD  = 2'd3
   } op_e;

endpackage

// File: rtl/ucs_sync.sv
module ucs_sync #(
   parameter int          NBITS   = 1,
   parameter int          STAGES  = 2,
   parameter logic [31:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] d,
   output logic [NBITS-1:0] q
);
   localparam logic [NBITS-1:0] INIT = RST_VAL[NBITS-1:0];

   logic [NBITS-1:0] stage_q [STAGES];

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[i] <= INIT;
               else        stage_q[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[i] <= INIT;
               else        stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ucs_edge.sv
module ucs_edge
   import ucs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic up_s,
   input  logic dn_s,
   output op_e  op
);
   logic up_prev, dn_prev;
   logic up_rise, dn_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_prev <= 1'b1;
         dn_prev <= 1'b1;
      end else begin
         up_prev <= up_s;
         dn_prev <= dn_s;
      end
   end

   assign up_rise = up_s & ~up_prev;
   assign dn_rise = dn_s & ~dn_prev;

   always_comb begin
      if (up_rise && dn_rise)  op = OP_BAD;
      else if (up_rise)        op = dn_s ? OP_INC : OP_BAD;
      else if (dn_rise)        op = up_s ? OP_DEC : OP_BAD;
      else                     op = OP_NONE;
   end
endmodule

// File: rtl/ucs_core.sv
module ucs_core
   import ucs_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  op_e              op,
   input  logic             up_s,
   input  logic             dn_s,
   output logic [WIDTH-1:0] count,
   output logic             carry_n,
   output logic             borrow_n,
   output logic             err
);
   localparam logic [WIDTH-1:0] CNT_MAX  = '1;
   localparam logic [WIDTH-1:0] CNT_ZERO = '0;

   logic [WIDTH-1:0] cnt_q;
   logic             carry_q, borrow_q, err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= CNT_ZERO;
         carry_q  <= 1'b1;
         borrow_q <= 1'b1;
         err_q    <= 1'b0;
      end else begin
         carry_q  <= !(!up_s && (cnt_q == CNT_MAX));
         borrow_q <= !(!dn_s && (clr || (cnt_q == CNT_ZERO)));
         err_q    <= (op == OP_BAD);
         if (clr) begin
            cnt_q <= CNT_ZERO;
         end else begin
            case (op)
               OP_INC:  cnt_q <= WIDTH'(cnt_q + 1'b1);
               OP_DEC:  cnt_q <= WIDTH'(cnt_q - 1'b1);
               default: cnt_q <= cnt_q;
            endcase
         end
      end
   end

   assign count    = cnt_q;
   assign carry_n  = carry_q;
   assign borrow_n = borrow_q;
   assign err      = err_q;
endmodule

// File: rtl/ucs_stage.sv
module ucs_stage
   import ucs_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_n,
   input  logic             dn_n,
   input  logic             clr,
   output logic [WIDTH-1:0] count,
   output logic             carry_n,
   output logic             borrow_n,
   output logic             busy,
   output logic             err
);
   initial begin
      assert (WIDTH >= 2) else $fatal(1, "ucs_stage: WIDTH must be at least 2");
      assert (SYNC_STAGES >= 2) else $fatal(1, "ucs_stage: SYNC_STAGES must be at least 2");
   end

   // bit 2: clear (idle low), bit 1: up (idle high), bit 0: down (idle high)
   localparam logic [31:0] SYNC_INIT = 32'b011;

   logic [2:0] raw_in, sync_out;
   logic       up_s, dn_s, clr_s;
   op_e        op;

   assign raw_in = {clr, up_n, dn_n};

   ucs_sync #(
      .NBITS   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_INIT)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign clr_s = sync_out[2];
   assign up_s  = sync_out[1];
   assign dn_s  = sync_out[0];

   ucs_edge edge_i (
      .clk   (clk),
      .rst_n (rst_n),
      .up_s  (up_s),
      .dn_s  (dn_s),
      .op    (op)
   );

   ucs_core #(
      .WIDTH (WIDTH)
   ) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_s),
      .op       (op),
      .up_s     (up_s),
      .dn_s     (dn_s),
      .count    (count),
      .carry_n  (carry_n),
      .borrow_n (borrow_n),
      .err      (err)
   );

   assign busy = ~(up_s & dn_s);
endmodule

// File: rtl/ucs_stage_chk.sv
module ucs_stage_chk
   import ucs_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr_s,
   input op_e              op,
   input logic [WIDTH-1:0] count,
   input logic             carry_n,
   input logic             borrow_n,
   input logic             busy,
   input logic             err
);
   localparam logic [WIDTH-1:0] CNT_MAX = '1;

   p_up_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_INC && !clr_s) |=> count == WIDTH'($past(count) + 1'b1));

   p_dn_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DEC && !clr_s) |=> count == WIDTH'($past(count) - 1'b1));

   p_bad_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_BAD && !clr_s) |=> ($stable(count) && err));

   p_err_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);

   p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_s |=> count == '0);

   p_carry_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(carry_n) && !err) |-> count == '0);

   p_borrow_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(borrow_n) && !err && !$past(clr_s)) |-> count == CNT_MAX);

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (carry_n && borrow_n));
endmodule

bind ucs_stage ucs_stage_chk #(.WIDTH(WIDTH)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr_s    (clr_s),
   .op       (op),
   .count    (count),
   .carry_n  (carry_n),
   .borrow_n (borrow_n),
   .busy     (busy),
   .err      (err)
);

// File: tb/ucs_stage_tb_top.sv
module ucs_stage_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         up_n = 1'b1;
   logic         dn_n = 1'b1;
   logic         clr = 1'b0;
   logic [W-1:0] lo_count, hi_count;
   logic         lo_carry_n, lo_borrow_n, hi_carry_n, hi_borrow_n;
   logic         lo_busy, hi_busy, lo_err, hi_err;

   int total = 0;
   int bad = 0;
   int lo_err_seen = 0;
   int hi_err_seen = 0;
   bit done = 1'b0;
   bit in_clr = 1'b0;
   logic [2*W-1:0] ref_val = '0;

   logic [2*W-1:0] exp_q [$];
   string          tag_q [$];

   always #2 clk = ~clk;

   ucs_stage #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n), .clr(clr),
      .count(lo_count), .carry_n(lo_carry_n), .borrow_n(lo_borrow_n),
      .busy(lo_busy), .err(lo_err)
   );

   ucs_stage #(.WIDTH(W), .SYNC_STAGES(2)) hi_i (
      .clk(clk), .rst_n(rst_n), .up_n(lo_carry_n), .dn_n(lo_borrow_n), .clr(clr),
      .count(hi_count), .carry_n(hi_carry_n), .borrow_n(hi_borrow_n),
      .busy(hi_busy), .err(hi_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && lo_err) lo_err_seen++;
      if (rst_n && hi_err) hi_err_seen++;
   end

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() != 0) begin
            automatic logic [2*W-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, {16'd0, hi_count, lo_count}, {16'd0, e});
         end
      end
   end

   task automatic push(input string tag);
      exp_q.push_back(ref_val);
      tag_q.push_back(tag);
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_up(input string tag);
      @(negedge clk);
      up_n = 1'b0;
      wait_n(8);
      chk("R9 busy during up", {31'd0, lo_busy}, 32'd1);
      chk("R5 low carry", {31'd0, lo_carry_n},
          {31'd0, !((ref_val[W-1:0] == 8'hFF) && !in_clr)});
      chk("R5 R10 upper carry", {31'd0, hi_carry_n},
          {31'd0, !((ref_val == 16'hFFFF) && !in_clr)});
      up_n = 1'b1;
      wait_n(10);
      chk("R9 busy idle", {31'd0, lo_busy}, 32'd0);
      if (!in_clr) ref_val = ref_val + 16'd1;
      push(tag);
   endtask

   task automatic pulse_dn(input string tag);
      @(negedge clk);
      dn_n = 1'b0;
      wait_n(8);
      chk("R9 busy during down", {31'd0, lo_busy}, 32'd1);
      chk("R6 R7 low borrow", {31'd0, lo_borrow_n},
          {31'd0, !((ref_val[W-1:0] == 8'h00) || in_clr)});
      chk("R6 R7 R10 upper borrow", {31'd0, hi_borrow_n},
          {31'd0, !((ref_val == 16'h0000) || in_clr)});
      dn_n = 1'b1;
      wait_n(10);
      if (!in_clr) ref_val = ref_val - 16'd1;
      push(tag);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      wait_n(4);
      rst_n = 1'b1;
      wait_n(2);
      // R8 reset state
      chk("R8 count", {16'd0, hi_count, lo_count}, 32'd0);
      chk("R8 carry idle", {30'd0, lo_carry_n, hi_carry_n}, 32'd3);
      chk("R8 borrow idle", {30'd0, lo_borrow_n, hi_borrow_n}, 32'd3);
      chk("R8 busy/err", {30'd0, lo_busy, lo_err}, 32'd0);

      for (int i = 0; i < 5; i++) pulse_up("R1 up count");
      for (int i = 0; i < 2; i++) pulse_dn("R2 down count");
      for (int i = 0; i < 3; i++) pulse_dn("R2 down to zero");
      pulse_dn("R6 R10 wrap down to all ones");
      pulse_up("R5 R10 wrap up to zero");
      for (int i = 0; i < 260; i++) pulse_up("R10 carry into upper byte");
      drain();
      chk("R10 after crossing", {16'd0, hi_count, lo_count}, 32'h0104);

      // R3 conflict: up pulse while down is held low
      begin
         automatic int e0 = lo_err_seen;
         automatic int e1 = hi_err_seen;
         @(negedge clk);
         dn_n = 1'b0;
         wait_n(6);
         up_n = 1'b0;
         wait_n(4);
         up_n = 1'b1;
         wait_n(8);
         chk("R3 count held", {16'd0, hi_count, lo_count}, 32'h0104);
         chk("R3 one err pulse", lo_err_seen - e0, 32'd1);
         chk("R3 upper no err", hi_err_seen - e1, 32'd0);
         dn_n = 1'b1;
         wait_n(10);
         ref_val = ref_val - 16'd1;
         push("R2 down after rejected up");
      end

      for (int i = 0; i < 5; i++) pulse_dn("R6 R10 borrow from upper byte");
      drain();
      chk("R10 after borrow", {16'd0, hi_count, lo_count}, 32'h00FE);

      // R4 / R7 clear
      @(negedge clk);
      clr = 1'b1;
      in_clr = 1'b1;
      wait_n(6);
      ref_val = '0;
      chk("R4 cleared", {16'd0, hi_count, lo_count}, 32'd0);
      pulse_up("R4 up ignored under clear");
      pulse_dn("R7 down under clear");
      drain();
      @(negedge clk);
      clr = 1'b0;
      in_clr = 1'b0;
      wait_n(6);
      pulse_up("R1 count after clear");
      drain();

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule